// File: doc/BRIEF.md
# Non-Retriggerable One-Shot Pulse Generator

This block is a synchronous monostable. It emits one output pulse, of a programmable length counted in clock cycles, when either of two trigger inputs sees an edge. One trigger is active-low and fires on its falling edge. The other is active-high and fires on its rising edge. Each trigger is honoured only while the other sits at its own active level, so the pair can also be used as an enable plus a trigger. Once a pulse is running, the block ignores every further trigger until the pulse has ended, so the pulse can never be stretched.

An active-low clear input overrides everything. Holding it low ends a running pulse at once and keeps the output idle. Releasing it can fire a pulse of its own, but only when, while clear was low, the triggers first passed through an idle state and then came back to the firing state. All three control inputs are asynchronous to the clock and are synchronised inside the block. The true output and its complement are both provided. A system reset puts the block in the cleared state at power-up.

Top module: `oneshot_pulse`

## Requirements
- R1: While rstN is low, and after it is released with no trigger, pulseQ is 0 and pulseQn is 1.
- R2: A 1-to-0 change on trigFallN starts a pulse while trigRise is 1 and clrN is 1. pulseQ goes high at the third rising clock edge after the input change. clrN counts as 1 only when its synchronised value was 1 in both the current and the previous sample.
- R3: A 0-to-1 change on trigRise starts a pulse while trigFallN is 0 and clrN is 1, with the same three-edge latency as R2.
- R4: A falling edge on trigFallN while trigRise is 0, and a rising edge on trigRise while trigFallN is 1, leave pulseQ at 0.
- R5: widthIn is sampled in the cycle a pulse starts, and pulseQ then stays high for exactly widthIn+1 cycles. A width of 0 gives a one-cycle pulse, and the all-ones width gives 2^WIDTH cycles.
- R6: Trigger edges that arrive while pulseQ is high, including in its last cycle, neither restart nor lengthen the pulse.
- R7: From the third rising edge after clrN goes low, pulseQ is 0 for as long as clrN stays low. This also cuts short any pulse in progress.
- R8: A pulse starts on release of clrN when trigFallN is 0 and trigRise is 1 at the release, provided that, while clrN was low, the inputs first went through trigFallN=1 or trigRise=0 and then returned to trigFallN=0 with trigRise=1.
- R9: Releasing clrN without that sequence starts no pulse, even if trigFallN=0 and trigRise=1 were held throughout.
- R10: pulseQn is the complement of pulseQ in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous power-up reset, active low |
| trigFallN | input | 1 | Trigger input that fires on its falling edge |
| trigRise | input | 1 | Trigger input that fires on its rising edge |
| clrN | input | 1 | Overriding clear, active low; its release can fire a pulse |
| widthIn | input | WIDTH | Pulse length minus one, in clock cycles |
| pulseQ | output | 1 | Pulse output, high while a pulse is active |
| pulseQn | output | 1 | Complement of pulseQ |

## Verification
The bench builds the block with WIDTH set to 6. This puts the all-ones width, a 64-cycle pulse, within a few hundred cycles, next to the zero-width single-cycle case. A scan of trigger offsets against a short pulse lands edges in the final pulse cycle and in the first idle cycle. The clear tests cover three cases: a pulse cut short, a release that follows a qualifying sequence, and a release where the inputs never left the firing state.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  // Strobes from the control state machine to the width counter
  typedef struct packed {
    logic load;  // capture a new width, pulse begins
    logic dec;   // count one cycle of an active pulse
  } osCtrlT;
endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int BITS = 3,
  parameter int STAGES = 2,
  parameter logic [BITS-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [BITS-1:0] din,
  output logic [BITS-1:0] syncOut,
  output logic [BITS-1:0] prevOut
);
  localparam int DEPTH = STAGES + 1;

  logic [BITS-1:0] stage [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[i] <= RST_VAL;
          else       stage[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[i] <= RST_VAL;
          else       stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
  assign prevOut = stage[STAGES];
endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   aNow,
  input  logic   aPrev,
  input  logic   bNow,
  input  logic   bPrev,
  input  logic   clrNow,
  input  logic   clrPrev,
  input  logic   cntZero,
  output osCtrlT strobe,
  output logic   active
);
  logic aFall, bRise, clrSettled, clrRelease;
  logic firing, edgeFire, releaseFire, fire;
  logic idleSeen, armed;

  assign aFall      = aPrev & ~aNow;
  assign bRise      = ~bPrev & bNow;
  assign clrSettled = clrNow & clrPrev;
  assign clrRelease = clrNow & ~clrPrev;
  assign firing     = ~aNow & bNow;

  assign edgeFire    = clrSettled & ((aFall & bNow) | (bRise & ~aNow));
  assign releaseFire = clrRelease & armed & firing;
  assign fire        = ~active & (edgeFire | releaseFire);

  // Pulse state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  active <= 1'b0;
    else if (!clrNow)           active <= 1'b0;
    else if (active && cntZero) active <= 1'b0;
    else if (fire)              active <= 1'b1;
  end

  // Release arming: idle state seen, then firing state while clear is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleSeen <= 1'b0;
      armed    <= 1'b0;
    end else if (clrNow) begin
      idleSeen <= 1'b0;
      armed    <= 1'b0;
    end else if (!firing) begin
      idleSeen <= 1'b1;
    end else if (idleSeen) begin
      armed    <= 1'b1;
    end
  end

  always_comb begin
    strobe      = '0;
    strobe.load = fire;
    strobe.dec  = active & ~cntZero & clrNow;
  end
endmodule

// File: rtl/oneshot_count.sv
module oneshot_count
  import oneshot_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  osCtrlT           strobe,
  input  logic [WIDTH-1:0] widthIn,
  output logic [WIDTH-1:0] cnt,
  output logic             cntZero
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (strobe.load) cnt <= widthIn;
    else if (strobe.dec)  cnt <= cnt - ONE;
  end

  assign cntZero = (cnt == '0);
endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse
  import oneshot_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigFallN,
  input  logic             trigRise,
  input  logic             clrN,
  input  logic [WIDTH-1:0] widthIn,
  output logic             pulseQ,
  output logic             pulseQn
);
  // Bit order inside the synchroniser: {clear, rise, fall}
  localparam logic [2:0] SYNC_RST = 3'b001;

  logic [2:0] syncNow, syncPrev;
  logic aNow, aPrev, bNow, bPrev, clrNow, clrPrev;
  logic [WIDTH-1:0] cnt;
  logic cntZero, active;
  osCtrlT strobe;

  oneshot_sync #(.BITS(3), .STAGES(2), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rstN(rstN),
    .din({clrN, trigRise, trigFallN}),
    .syncOut(syncNow), .prevOut(syncPrev)
  );

  assign {clrNow, bNow, aNow}    = syncNow;
  assign {clrPrev, bPrev, aPrev} = syncPrev;

  oneshot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .aNow(aNow), .aPrev(aPrev), .bNow(bNow), .bPrev(bPrev),
    .clrNow(clrNow), .clrPrev(clrPrev), .cntZero(cntZero),
    .strobe(strobe), .active(active)
  );

  oneshot_count #(.WIDTH(WIDTH)) u_count (
    .clk(clk), .rstN(rstN), .strobe(strobe), .widthIn(widthIn),
    .cnt(cnt), .cntZero(cntZero)
  );

  assign pulseQ  = active;
  assign pulseQn = ~active;
endmodule

// File: rtl/oneshot_pulse_chk.sv
module oneshot_pulse_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             clrSync,
  input logic             pulseQ,
  input logic [WIDTH-1:0] cnt,
  input logic [WIDTH-1:0] widthIn
);
  AST_CLEAR_KILLS: assert property (@(posedge clk) disable iff (!rstN)
    !clrSync |=> !pulseQ); // R7

  AST_WIDTH_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseQ) |-> cnt == $past(widthIn)); // R5

  AST_NO_EXTEND: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ && clrSync && cnt != '0 |=> pulseQ && cnt == $past(cnt) - WIDTH'(1)); // R6

  AST_PULSE_END: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ && cnt == '0 |=> !pulseQ); // R5

  AST_START_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseQ) |-> $past(clrSync)); // R7
endmodule

bind oneshot_pulse oneshot_pulse_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .clrSync(clrNow),
  .pulseQ(pulseQ), .cnt(cnt), .widthIn(widthIn)
);

// File: tb/oneshot_pulse_test.sv
`timescale 1ns/1ps
module oneshot_pulse_test;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigFallN = 1'b1, trigRise = 1'b0, clrN = 1'b1;
  logic [W-1:0] widthIn = '0;
  logic pulseQ, pulseQn;

  int checks = 0, fails = 0;
  string phase = "R1";
  bit done = 0;

  // Reference model state
  bit mQ = 0;
  int mCnt = 0;
  bit mSeen = 0, mArmed = 0;
  bit hA[3], hB[3], hC[3];

  always #2.5 clk = ~clk;

  oneshot_pulse #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .trigFallN(trigFallN), .trigRise(trigRise),
    .clrN(clrN), .widthIn(widthIn), .pulseQ(pulseQ), .pulseQn(pulseQn)
  );

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: hX[k] holds the input seen k+1 edges ago
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mQ = 0; mCnt = 0; mSeen = 0; mArmed = 0;
      for (int k = 0; k < 3; k++) begin hA[k] = 1; hB[k] = 0; hC[k] = 0; end
    end else begin
      bit trig, rel, go;
      trig = hC[1] && hC[2] &&
             ((hA[2] && !hA[1] && hB[1]) || (!hB[2] && hB[1] && !hA[1]));
      rel  = hC[1] && !hC[2] && mArmed && !hA[1] && hB[1];
      go   = !mQ && (trig || rel);
      if (!hC[1]) mQ = 0;
      else if (mQ) begin
        if (mCnt == 0) mQ = 0; else mCnt--;
      end else if (go) begin
        mQ = 1; mCnt = int'(widthIn);
      end
      if (hC[1]) begin mSeen = 0; mArmed = 0; end
      else if (hA[1] || !hB[1]) mSeen = 1;
      else if (mSeen) mArmed = 1;
      for (int k = 2; k > 0; k--) begin hA[k] = hA[k-1]; hB[k] = hB[k-1]; hC[k] = hC[k-1]; end
      hA[0] = trigFallN; hB[0] = trigRise; hC[0] = clrN;
    end
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(phase, pulseQ, mQ);
      check("R10", pulseQn, ~pulseQ);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(3);
    check("R1", pulseQ, 1'b0);
    check("R1", pulseQn, 1'b1);
    rstN = 1'b1;
    step(6);
    check("R1", pulseQ, 1'b0);

    // R4: rising trigRise while trigFallN high is blocked
    phase = "R4";
    trigRise = 1'b1; step(6);
    check("R4", pulseQ, 1'b0);

    // R2: falling trigFallN with trigRise high, width 4 -> 5 cycles
    phase = "R2";
    widthIn = 6'd4;
    trigFallN = 1'b0; step(3);
    check("R2", pulseQ, 1'b1);
    step(4); check("R5", pulseQ, 1'b1);
    step(1); check("R5", pulseQ, 1'b0);

    // R3: rising trigRise with trigFallN low, width 0 -> one cycle
    phase = "R3";
    widthIn = 6'd0;
    trigRise = 1'b0; step(4);
    trigRise = 1'b1; step(3);
    check("R3", pulseQ, 1'b1);
    step(1); check("R5", pulseQ, 1'b0);

    // R4: falling trigFallN while trigRise low is blocked
    phase = "R4";
    trigFallN = 1'b1; trigRise = 1'b0; step(4);
    trigFallN = 1'b0; step(6);
    check("R4", pulseQ, 1'b0);

    // R6: edges during a pulse are ignored
    phase = "R6";
    widthIn = 6'd9;
    trigFallN = 1'b1; trigRise = 1'b1; step(4);
    trigFallN = 1'b0; step(3);
    check("R6", pulseQ, 1'b1);
    for (int i = 0; i < 3; i++) begin
      trigFallN = 1'b1; step(1); trigFallN = 1'b0; step(1);
    end
    step(3); check("R6", pulseQ, 1'b1);
    step(1); check("R6", pulseQ, 1'b0);
    step(6);

    // R6: scan trigger offsets around the end of a short pulse
    widthIn = 6'd2;
    for (int off = 0; off < 8; off++) begin
      trigFallN = 1'b1; step(4);
      trigFallN = 1'b0; step(off);
      trigFallN = 1'b1; step(1);
      trigFallN = 1'b0; step(12);
    end

    // R5: all-ones width gives 64 cycles
    phase = "R5";
    widthIn = '1;
    trigFallN = 1'b1; step(4);
    trigFallN = 1'b0; step(3);
    check("R5", pulseQ, 1'b1);
    step(63); check("R5", pulseQ, 1'b1);
    step(1);  check("R5", pulseQ, 1'b0);

    // R7: clear cuts a running pulse short
    phase = "R7";
    widthIn = 6'd40;
    trigFallN = 1'b1; step(4);
    trigFallN = 1'b0; step(8);
    check("R7", pulseQ, 1'b1);
    clrN = 1'b0; step(3);
    check("R7", pulseQ, 1'b0);
    trigFallN = 1'b1; step(3); trigFallN = 1'b0; step(6);
    check("R7", pulseQ, 1'b0);

    // R8: idle then firing state while cleared, release fires
    phase = "R8";
    widthIn = 6'd3;
    clrN = 1'b1; step(8);
    clrN = 1'b0; step(4);
    trigFallN = 1'b1; step(4);
    trigFallN = 1'b0; step(4);
    clrN = 1'b1; step(3);
    check("R8", pulseQ, 1'b1);
    step(4); check("R8", pulseQ, 1'b0);

    // R9: firing state held through the clear, release does not fire
    phase = "R9";
    clrN = 1'b0; step(8);
    clrN = 1'b1; step(8);
    check("R9", pulseQ, 1'b0);

    step(4);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule